// File: doc/BRIEF.md
# Multichannel Sinc Decimation Filter with Restart Pulse

This block turns single-bit sigma-delta streams into signed 16-bit samples. A bank of identical channels shares one bit strobe, one set of settings (filter order, oversampling ratio, output shift) and one restart pulse. Each channel has its own data bit and its own channel enable. The filter order is either first-order (a plain count of ones per window) or third-order (three cascaded integrators and three differentiators in modular arithmetic). Every window of `cfg_osr` strobed bits, a channel yields a bipolar result: twice the sinc sum minus the full scale, where the full scale is OSR for first order and OSR cubed for third order. The result is arithmetically right-shifted and saturated into 16 bits.

Each channel is governed by a three-state controller. CH_OFF means the channel is not running. The transition OFF→SETTLE (third order) or OFF→RUN (first order) is taken when both the master enable and the channel enable are high. In CH_SETTLE the first two decimation results are computed but discarded. The transition SETTLE→RUN is taken on the second discarded window end. CH_RUN publishes every window. The transition RUN→SETTLE is taken on a restart pulse in third order, while first order stays in RUN. Any state goes to CH_OFF when either enable drops. The entry from OFF and every restart pulse clear the window counter and all filter state. Channels that start from the same master rising edge, or that share a restart pulse, therefore publish in the same cycle.

A published sample raises a one-cycle `out_valid` and sets a sticky acknowledge flag. Software clears that flag by writing one to its `ack_clr` bit.

Top module: `sdf_decim_bank`

## Requirements
- R1: After reset, every `ack_flag`, `out_valid` and `out_data` bit is 0.
- R2: First order (`cfg_sinc3`=0): with k ones among the OSR strobed bits of a window, the published value before scaling is 2k − OSR, and the first window after a start is already published.
- R3: Third order (`cfg_sinc3`=1): for a stream in which every OSR consecutive strobed bits hold k ones, every published value before scaling is 2·k·OSR² − OSR³.
- R4: The output is the pre-scaling value arithmetically shifted right by `cfg_shift` (rounding toward minus infinity), then saturated to the range −32768..32767. The result is presented as two's complement on `out_data`.
- R5: A bit on `bit_data` counts only in a cycle where `bit_valid` is 1. Data in other cycles has no effect.
- R6: In third order, the first two window ends after a start or a restart produce no `out_valid`, set no flag and leave `out_data` unchanged. The third and later window ends publish.
- R7: A `sync_pulse` cycle drops that cycle's bit, clears the window counter and the filter state of every running channel, and the next window ends exactly OSR strobed bits later.
- R8: Each publication sets that channel's `ack_flag`. The flag stays set until a cycle with its `ack_clr` bit at 1. A publication in the same cycle as a clear leaves the flag set.
- R9: While `master_en` is 0, or a channel's `ch_en` bit is 0, that channel publishes nothing and sets no flag.
- R10: Channels started by the same `master_en` rising edge, or restarted by the same `sync_pulse`, raise `out_valid` in the same cycle.
- R11: `out_valid` is a one-cycle pulse. It rises only in the cycle after the clock edge that takes the last strobed bit of a window, together with the new `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Gates all channels; rising edge starts enabled channels together |
| ch_en | input | N_CH | Per-channel enable |
| cfg_sinc3 | input | 1 | 0 first-order, 1 third-order filter |
| cfg_osr | input | OSR_W | Oversampling ratio, 2..OSR_MAX |
| cfg_shift | input | SH_W | Right shift applied before saturation |
| sync_pulse | input | 1 | Restarts the window and filter state of running channels |
| bit_valid | input | 1 | Strobe marking a modulator bit |
| bit_data | input | N_CH | One modulator bit per channel |
| ack_clr | input | N_CH | Write-one-to-clear for the acknowledge flags |
| ack_flag | output | N_CH | Sticky per-channel acknowledge flags |
| out_valid | output | N_CH | One-cycle pulse per published sample |
| out_data | output | 16·N_CH | Signed samples, channel c at bits 16c+15..16c |

## Verification
A wrong window counter shows up as an `out_valid` pulse outside a window boundary, or as a sample count that does not match the bits driven. This is visible within one window of OSR strobed bits. A corrupted integrator or differentiator gives a published value that differs from the closed-form density formula at the very next publication. A wrong discard count in the settle state shows as a sample too many or too few within three windows of a start or restart. Flag and enable faults appear on `ack_flag` one cycle after the offending edge.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

    typedef enum logic [1:0] {
        CH_OFF    = 2'd0,
        CH_SETTLE = 2'd1,
        CH_RUN    = 2'd2
    } ch_state_t;

    localparam int unsigned OUT_W     = 16;
    localparam int unsigned MAX_ORDER = 3;

endpackage

// File: rtl/sdf_integ_chain.sv
module sdf_integ_chain #(
    parameter int ACC_W  = 25,
    parameter int STAGES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             din,
    output logic [ACC_W-1:0] tap_first,
    output logic [ACC_W-1:0] tap_last
);

    logic [ACC_W-1:0] acc_q [STAGES];
    logic [ACC_W-1:0] acc_d [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign acc_d[g] = acc_q[g] + ACC_W'(din);
        end else begin : g_tail
            assign acc_d[g] = acc_q[g] + acc_d[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q[g] <= '0;
            end else if (clr) begin
                acc_q[g] <= '0;
            end else if (step) begin
                acc_q[g] <= acc_d[g];
            end
        end
    end

    // Taps expose the post-update sums so the window-closing bit is included
    assign tap_first = acc_d[0];
    assign tap_last  = acc_d[STAGES-1];

endmodule

// File: rtl/sdf_comb_chain.sv
module sdf_comb_chain #(
    parameter int ACC_W  = 25,
    parameter int STAGES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [ACC_W-1:0] din,
    output logic [ACC_W-1:0] tap_first,
    output logic [ACC_W-1:0] tap_last
);

    logic [ACC_W-1:0] dly_q [STAGES];
    logic [ACC_W-1:0] diff  [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign diff[g] = din - dly_q[g];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dly_q[g] <= '0;
                end else if (clr) begin
                    dly_q[g] <= '0;
                end else if (load) begin
                    dly_q[g] <= din;
                end
            end
        end else begin : g_tail
            assign diff[g] = diff[g-1] - dly_q[g];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dly_q[g] <= '0;
                end else if (clr) begin
                    dly_q[g] <= '0;
                end else if (load) begin
                    dly_q[g] <= diff[g-1];
                end
            end
        end
    end

    assign tap_first = diff[0];
    assign tap_last  = diff[STAGES-1];

endmodule

// File: rtl/sdf_chan_ctrl.sv
module sdf_chan_ctrl
    import sdf_pkg::*;
#(
    parameter int OSR_W    = 9,
    parameter int SETTLE_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sync,
    input  logic             sinc3,
    input  logic [OSR_W-1:0] osr,
    input  logic             bit_valid,
    output logic             restart,
    output logic             step,
    output logic             decim,
    output logic             publish
);

    localparam int DISC_W = $clog2(SETTLE_N + 1);

    ch_state_t         state_q;
    ch_state_t         state_d;
    logic [OSR_W-1:0]  cnt_q;
    logic [DISC_W-1:0] disc_q;
    logic              win_end;

    // Strobes derived from the current state
    always_comb begin
        restart = run && ((state_q == CH_OFF) || sync);
        step    = run && (state_q != CH_OFF) && !sync && bit_valid;
        win_end = (cnt_q == (osr - OSR_W'(1)));
        decim   = step && win_end;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (run) begin
                    state_d = sinc3 ? CH_SETTLE : CH_RUN;
                end
            end
            CH_SETTLE: begin
                if (!run) begin
                    state_d = CH_OFF;
                end else if (sync) begin
                    state_d = sinc3 ? CH_SETTLE : CH_RUN;
                end else if (decim && (disc_q == DISC_W'(1))) begin
                    state_d = CH_RUN;
                end
            end
            CH_RUN: begin
                if (!run) begin
                    state_d = CH_OFF;
                end else if (sync && sinc3) begin
                    state_d = CH_SETTLE;
                end
            end
            default: state_d = CH_OFF;
        endcase
    end

    // State register with window and discard counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
            cnt_q   <= '0;
            disc_q  <= '0;
        end else begin
            state_q <= state_d;
            if (restart) begin
                cnt_q  <= '0;
                disc_q <= DISC_W'(SETTLE_N);
            end else if (step) begin
                cnt_q <= win_end ? '0 : cnt_q + OSR_W'(1);
                if (decim && (state_q == CH_SETTLE)) begin
                    disc_q <= disc_q - DISC_W'(1);
                end
            end
        end
    end

    // Outputs
    always_comb begin
        publish = decim && (state_q == CH_RUN);
    end

    // R7
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_OFF) |-> (cnt_q < osr));

    // R6
    sync_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && run && sinc3) |=> (state_q == CH_SETTLE));

    // R9
    stop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (state_q == CH_OFF));

endmodule

// File: rtl/sdf_chan.sv
module sdf_chan
    import sdf_pkg::*;
#(
    parameter int OSR_W = 9,
    parameter int ACC_W = 25,
    parameter int RES_W = 27,
    parameter int SH_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sync,
    input  logic             sinc3,
    input  logic [OSR_W-1:0] osr,
    input  logic [SH_W-1:0]  shift,
    input  logic [ACC_W-1:0] full,
    input  logic             bit_valid,
    input  logic             bit_data,
    input  logic             ack_clr,
    output logic             ack_flag,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);

    localparam logic signed [RES_W-1:0] SAT_HI = RES_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [RES_W-1:0] SAT_LO = -SAT_HI - RES_W'(1);

    logic             restart;
    logic             step;
    logic             decim;
    logic             publish;
    logic [ACC_W-1:0] int_first;
    logic [ACC_W-1:0] int_last;
    logic [ACC_W-1:0] comb_in;
    logic [ACC_W-1:0] comb_first;
    logic [ACC_W-1:0] comb_last;
    logic [ACC_W-1:0] raw;

    logic signed [RES_W-1:0] bipolar;
    logic signed [RES_W-1:0] scaled;
    logic        [OUT_W-1:0] clipped;

    logic             ack_q;
    logic             ov_q;
    logic [OUT_W-1:0] dout_q;

    sdf_chan_ctrl #(
        .OSR_W    (OSR_W),
        .SETTLE_N (MAX_ORDER - 1)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sync      (sync),
        .sinc3     (sinc3),
        .osr       (osr),
        .bit_valid (bit_valid),
        .restart   (restart),
        .step      (step),
        .decim     (decim),
        .publish   (publish)
    );

    sdf_integ_chain #(
        .ACC_W  (ACC_W),
        .STAGES (MAX_ORDER)
    ) u_integ (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (restart),
        .step      (step),
        .din       (bit_data),
        .tap_first (int_first),
        .tap_last  (int_last)
    );

    assign comb_in = sinc3 ? int_last : int_first;

    sdf_comb_chain #(
        .ACC_W  (ACC_W),
        .STAGES (MAX_ORDER)
    ) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (restart),
        .load      (decim),
        .din       (comb_in),
        .tap_first (comb_first),
        .tap_last  (comb_last)
    );

    // Bipolar conversion, shift and saturation
    always_comb begin
        raw     = sinc3 ? comb_last : comb_first;
        bipolar = $signed({1'b0, raw, 1'b0}) - $signed({2'b00, full});
        scaled  = bipolar >>> shift;
        if (scaled > SAT_HI) begin
            clipped = SAT_HI[OUT_W-1:0];
        end else if (scaled < SAT_LO) begin
            clipped = SAT_LO[OUT_W-1:0];
        end else begin
            clipped = scaled[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q  <= 1'b0;
            ov_q   <= 1'b0;
            dout_q <= '0;
        end else begin
            ov_q  <= publish;
            ack_q <= publish | (ack_q & ~ack_clr);
            if (publish) begin
                dout_q <= clipped;
            end
        end
    end

    assign ack_flag  = ack_q;
    assign out_valid = ov_q;
    assign out_data  = dout_q;

    // R8
    ack_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && !ack_clr) |=> ack_q);

    // R8
    valid_sets_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ov_q |-> ack_q);

    // R11
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ov_q |-> $stable(dout_q));

    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_q && osr > OSR_W'(1)) |=> !ov_q);

endmodule

// File: rtl/sdf_decim_bank.sv
module sdf_decim_bank
    import sdf_pkg::*;
#(
    parameter int N_CH    = 4,
    parameter int OSR_MAX = 256,
    localparam int OSR_W  = $clog2(OSR_MAX + 1),
    localparam int ACC_W  = MAX_ORDER * $clog2(OSR_MAX) + 1,
    localparam int RES_W  = ACC_W + 2,
    localparam int SH_W   = $clog2(RES_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  master_en,
    input  logic [N_CH-1:0]       ch_en,
    input  logic                  cfg_sinc3,
    input  logic [OSR_W-1:0]      cfg_osr,
    input  logic [SH_W-1:0]       cfg_shift,
    input  logic                  sync_pulse,
    input  logic                  bit_valid,
    input  logic [N_CH-1:0]       bit_data,
    input  logic [N_CH-1:0]       ack_clr,
    output logic [N_CH-1:0]       ack_flag,
    output logic [N_CH-1:0]       out_valid,
    output logic [N_CH*OUT_W-1:0] out_data
);

    localparam int CUBE_W = MAX_ORDER * OSR_W;

    logic [CUBE_W-1:0] osr_wide;
    logic [CUBE_W-1:0] osr_cube;
    logic [ACC_W-1:0]  full_scale;

    // Shared full-scale value: OSR for first order, OSR cubed for third
    always_comb begin
        osr_wide   = {{(CUBE_W - OSR_W){1'b0}}, cfg_osr};
        osr_cube   = osr_wide * osr_wide * osr_wide;
        full_scale = cfg_sinc3 ? osr_cube[ACC_W-1:0]
                               : {{(ACC_W - OSR_W){1'b0}}, cfg_osr};
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        sdf_chan #(
            .OSR_W (OSR_W),
            .ACC_W (ACC_W),
            .RES_W (RES_W),
            .SH_W  (SH_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (master_en & ch_en[c]),
            .sync      (sync_pulse),
            .sinc3     (cfg_sinc3),
            .osr       (cfg_osr),
            .shift     (cfg_shift),
            .full      (full_scale),
            .bit_valid (bit_valid),
            .bit_data  (bit_data[c]),
            .ack_clr   (ack_clr[c]),
            .ack_flag  (ack_flag[c]),
            .out_valid (out_valid[c]),
            .out_data  (out_data[c*OUT_W +: OUT_W])
        );
    end

    // R9
    master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_en && !$rose(master_en)) |=> (out_valid == '0));

endmodule

// File: tb/sdf_decim_bank_tb_top.sv
`timescale 1ns/1ps
module sdf_decim_bank_tb_top;

    localparam int N_CH = 4;
    localparam int OW   = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             master_en;
    logic [N_CH-1:0]  ch_en;
    logic             cfg_sinc3;
    logic [8:0]       cfg_osr;
    logic [4:0]       cfg_shift;
    logic             sync_pulse;
    logic             bit_valid;
    logic [N_CH-1:0]  bit_data;
    logic [N_CH-1:0]  ack_clr;
    logic [N_CH-1:0]  ack_flag;
    logic [N_CH-1:0]  out_valid;
    logic [N_CH*OW-1:0] out_data;

    int     n_checks = 0;
    int     n_fails  = 0;
    int     k_ch     [N_CH];
    int     pubs     [N_CH];
    longint exp_val  [N_CH];
    logic [N_CH-1:0] en_mask;
    logic [N_CH-1:0] ov_prev;
    int     osr_b;
    int     bidx;
    string  cur_req;

    always #10 clk = ~clk;

    sdf_decim_bank #(.N_CH(N_CH), .OSR_MAX(256)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_en  (master_en),
        .ch_en      (ch_en),
        .cfg_sinc3  (cfg_sinc3),
        .cfg_osr    (cfg_osr),
        .cfg_shift  (cfg_shift),
        .sync_pulse (sync_pulse),
        .bit_valid  (bit_valid),
        .bit_data   (bit_data),
        .ack_clr    (ack_clr),
        .ack_flag   (ack_flag),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic longint expect_out(input bit s3, input int osr, input int sh, input int k);
        longint r;
        if (s3) r = 2 * longint'(k) * osr * osr - longint'(osr) * osr * osr;
        else    r = 2 * longint'(k) - osr;
        r = r >>> sh;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    // Sample outputs at the falling edge
    task automatic clk_step();
        @(negedge clk);
        for (int i = 0; i < N_CH; i++) begin
            if (out_valid[i]) begin
                pubs[i]++;
                check($signed(out_data[i*OW +: OW]) == exp_val[i], cur_req,
                      $signed(out_data[i*OW +: OW]), exp_val[i]);
                check(ack_flag[i] == 1'b1, "R8 flag with sample", ack_flag[i], 1);
                // R11: one-cycle pulse
                check(!ov_prev[i], "R11 pulse width", ov_prev[i], 0);
            end
        end
        // R10: simultaneous publication
        if (out_valid != '0) check(out_valid == en_mask, "R10 aligned", out_valid, en_mask);
        ov_prev = out_valid;
    endtask

    task automatic clear_pubs();
        for (int i = 0; i < N_CH; i++) pubs[i] = 0;
    endtask

    task automatic start_run(input bit s3, input int osr, input int sh, input logic [N_CH-1:0] mask);
        clk_step();
        master_en = 1'b0;
        clk_step();
        cfg_sinc3 = s3; cfg_osr = 9'(osr); cfg_shift = 5'(sh); ch_en = mask;
        osr_b = osr; en_mask = mask;
        for (int i = 0; i < N_CH; i++) exp_val[i] = expect_out(s3, osr, sh, k_ch[i]);
        clk_step();
        master_en = 1'b1;
        bidx = 0;
        clear_pubs();
    endtask

    // Each bit: one strobed cycle, then one unstrobed cycle carrying inverted data (R5)
    task automatic drive_bits(input int n, input bit clr_last);
        for (int b = 0; b < n; b++) begin
            clk_step();
            bit_valid = 1'b1;
            for (int i = 0; i < N_CH; i++) bit_data[i] = ((bidx % osr_b) < k_ch[i]);
            if (clr_last && b == n - 1) ack_clr = '1;
            clk_step();
            ack_clr = '0;
            // R11: no sample unless this bit closed a window
            if ((bidx % osr_b) != osr_b - 1) check(out_valid == '0, "R11 timing", out_valid, 0);
            bit_valid = 1'b0;
            bit_data = ~bit_data;
            bidx++;
        end
    endtask

    task automatic do_sync();
        clk_step();
        sync_pulse = 1'b1; bit_valid = 1'b1; bit_data = '1;
        clk_step();
        sync_pulse = 1'b0; bit_valid = 1'b0;
        bidx = 0;
        clear_pubs();
    endtask

    task automatic expect_pubs(input int n, input string req);
        for (int i = 0; i < N_CH; i++)
            check(pubs[i] == (en_mask[i] ? n : 0), req, pubs[i], en_mask[i] ? n : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; master_en = 1'b0; ch_en = '0; cfg_sinc3 = 1'b0; cfg_osr = 9'd8;
        cfg_shift = '0; sync_pulse = 1'b0; bit_valid = 1'b0; bit_data = '0; ack_clr = '0;
        en_mask = '0; ov_prev = '0; osr_b = 8; bidx = 0; cur_req = "R1";
        for (int i = 0; i < N_CH; i++) begin k_ch[i] = 0; exp_val[i] = 0; pubs[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clk_step();
        // R1 reset state
        check(ack_flag == '0, "R1 flags", ack_flag, 0);
        check(out_valid == '0, "R1 valid", out_valid, 0);
        check(out_data == '0, "R1 data", out_data, 0);

        // R2 R5: first-order sweep of every density at OSR 8
        cur_req = "R2 R5 first-order value";
        for (int kk = 0; kk <= 8; kk++) begin
            for (int i = 0; i < N_CH; i++) k_ch[i] = (kk + i) % 9;
            start_run(1'b0, 8, 0, 4'hF);
            drive_bits(16, 1'b0);
            expect_pubs(2, "R2 sample count");
        end

        // R3 R6: third-order sweep at OSR 4, two discarded windows
        cur_req = "R3 R5 third-order value";
        for (int kk = 0; kk <= 4; kk++) begin
            for (int i = 0; i < N_CH; i++) k_ch[i] = (kk + i) % 5;
            start_run(1'b1, 4, 0, 4'hF);
            drive_bits(8, 1'b0);
            expect_pubs(0, "R6 settle discard");
            drive_bits(8, 1'b0);
            expect_pubs(2, "R6 settled count");
        end

        // R4: saturation at OSR 256 with shift 9
        cur_req = "R4 saturation";
        k_ch[0] = 0; k_ch[1] = 128; k_ch[2] = 255; k_ch[3] = 256;
        start_run(1'b1, 256, 9, 4'hF);
        check(exp_val[3] == 32767 && exp_val[0] == -32768, "R4 model", exp_val[3], 32767);
        drive_bits(768, 1'b0);
        expect_pubs(1, "R4 sample count");

        // R4: arithmetic shift of negative values
        cur_req = "R4 shift";
        k_ch[0] = 3; k_ch[1] = 0; k_ch[2] = 16; k_ch[3] = 9;
        start_run(1'b0, 16, 2, 4'hF);
        drive_bits(32, 1'b0);
        expect_pubs(2, "R4 shift count");

        // R8: sticky flags and write-one-to-clear
        clk_step(); ack_clr = 4'b0001;
        clk_step(); ack_clr = '0;
        check(ack_flag == 4'b1110, "R8 partial clear", ack_flag, 4'b1110);
        repeat (5) clk_step();
        check(ack_flag == 4'b1110, "R8 sticky", ack_flag, 4'b1110);
        ack_clr = '1;
        clk_step(); ack_clr = '0;
        check(ack_flag == '0, "R8 full clear", ack_flag, 0);
        cur_req = "R8 set wins value";
        k_ch[0] = 2; k_ch[1] = 4; k_ch[2] = 6; k_ch[3] = 8;
        start_run(1'b0, 8, 0, 4'hF);
        drive_bits(8, 1'b1);
        clk_step();
        check(ack_flag == 4'hF, "R8 set wins over clear", ack_flag, 4'hF);

        // R9: master off, then partial channel enables
        ack_clr = '1; clk_step(); ack_clr = '0;
        cur_req = "R9 value";
        start_run(1'b0, 8, 0, 4'hF);
        master_en = 1'b0;
        drive_bits(16, 1'b0);
        for (int i = 0; i < N_CH; i++) check(pubs[i] == 0, "R9 master off", pubs[i], 0);
        check(ack_flag == '0, "R9 no flag", ack_flag, 0);
        start_run(1'b0, 8, 0, 4'b0101);
        drive_bits(16, 1'b0);
        expect_pubs(2, "R9 channel enable");
        clk_step();
        check(ack_flag == 4'b0101, "R9 flags", ack_flag, 4'b0101);

        // R7: restart mid-window, first order
        cur_req = "R7 after restart";
        k_ch[0] = 1; k_ch[1] = 5; k_ch[2] = 8; k_ch[3] = 3;
        start_run(1'b0, 8, 0, 4'hF);
        drive_bits(11, 1'b0);
        expect_pubs(1, "R7 before restart");
        do_sync();
        drive_bits(7, 1'b0);
        expect_pubs(0, "R7 window restarted");
        drive_bits(1, 1'b0);
        expect_pubs(1, "R7 window length");

        // R6 R7: restart mid-stream, third order
        cur_req = "R6 after restart";
        k_ch[0] = 0; k_ch[1] = 2; k_ch[2] = 3; k_ch[3] = 4;
        start_run(1'b1, 4, 0, 4'hF);
        drive_bits(14, 1'b0);
        expect_pubs(1, "R6 before restart");
        do_sync();
        drive_bits(8, 1'b0);
        expect_pubs(0, "R6 discard after restart");
        drive_bits(4, 1'b0);
        expect_pubs(1, "R6 publish after settle");

        repeat (3) clk_step();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule